// File: doc/BRIEF.md
# SPI Serial Flash Target Model

This block is a synthesizable SPI target that acts like a small serial flash memory. It lets a bench or an FPGA prototype talk to a flash-like device without a real part. The host drives chip-select, serial clock, serial data in and a hold line. The block answers on a serial data output that has a separate output-enable, so the pad or the bench can tri-state it. Inside it keeps a byte array that starts erased. It accepts four commands: set the write latch, read status, read data and program one byte.

All host pins are brought into the system clock through synchronizers, and serial clock edges are found by oversampling. The serial clock must therefore stay high and low for at least three system clocks each. A program is accepted only when chip-select rises at the end of a complete frame, and only after the write latch has been set. It then runs for a fixed number of system clocks, during which a busy flag is set. Programming can only clear bits, so a byte can be rewritten only toward zero until it is erased again.

Top module: `spif_target`

## Requirements
- R1: After reset every array byte reads 0xFF, the status byte reads 0x00 and `sdo_oe` is low.
- R2: Serial mode 0 (clock idle low) and mode 3 (clock idle high) both work. `sdi` is sampled on the rising clock edge, `sdo` changes after the falling edge, and every byte travels most significant bit first.
- R3: Opcode 0x06 in a frame of exactly 8 bits sets the write latch (status bit 1) when chip-select rises. It is ignored while busy.
- R4: Opcode 0x05 returns the status byte {6'b0, write latch, busy} (busy in bit 0). The byte repeats for as long as the host keeps clocking.
- R5: Opcode 0x03, followed by a 24-bit address, returns data starting at that address. The address advances by one for each further byte. Only the low log2(MEM_BYTES) address bits select the byte. If busy was set when the opcode completed, the frame drives no data.
- R6: Opcode 0x02 with a 24-bit address and one data byte starts a program only under all of these conditions: chip-select rises after exactly 40 bits, the write latch is set and busy is clear. Otherwise the array is unchanged.
- R7: A program stores (old byte AND new byte), so bits only go from 1 to 0.
- R8: A started program holds busy at 1 for PROG_CYCLES system clocks. When busy falls, the byte has been written and the write latch is cleared.
- R9: A program whose byte index is PROT_START or above (0xC0 by default) is ignored. The write latch stays set and busy stays clear.
- R10: While `hold_n` is low during a selected frame, serial clock edges are ignored and `sdo_oe` is low. The frame resumes where it stopped once `hold_n` returns high.
- R11: `sdo_oe` is high only while status or read data is being shifted out. It is never high during opcode or address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause of the serial sequence |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo` (low means high impedance) |

## Verification
A wrong bit counter or a missed clock edge moves every later field of the frame. It shows up at once as read data rotated by bits or as a wrong address in the next read byte. A wrong busy or write-latch state is visible in the next status read, and its effect on programming appears within one program period as a byte that changed when it should not, or stayed unchanged when it should have changed. A bad array merge shows up in the first read after busy falls, as a bit that went from 0 back to 1.

// File: rtl/spif_pkg.sv
`timescale 1ns/1ps
package spif_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [5:0] B_CMD   = 6'd8;
  localparam logic [5:0] B_ADDR  = 6'd32;
  localparam logic [5:0] B_PROG  = 6'd40;
  localparam logic [5:0] B_WRAP  = 6'd47;
endpackage

// File: rtl/spif_sync.sv
`timescale 1ns/1ps
module spif_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spif_array.sv
`timescale 1ns/1ps
module spif_array #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] ra_idx,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [7:0]    rb_data
);
  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
    end else if (wr_en) begin
      cell_q[wr_idx] <= wr_data;
    end
  end

  assign ra_data = cell_q[ra_idx];
  assign rb_data = cell_q[rb_idx];

  // R7: a stored byte may only lose ones
  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    a_r7_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cell_q[g]) |-> ((cell_q[g] & ~$past(cell_q[g])) == 8'h00));
  end
endmodule

// File: rtl/spif_prog.sv
`timescale 1ns/1ps
module spif_prog #(
  parameter int AW = 8,
  parameter int PROG_CYCLES = 64,
  parameter int PROT_START = 192,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end_i,
  input  logic          prog_ok_i,
  input  logic          wren_ok_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    data_i,
  input  logic [7:0]    old_i,
  output logic [AW-1:0] tgt_idx_o,
  output logic          wr_en_o,
  output logic [7:0]    wr_data_o,
  output logic          busy_o,
  output logic [7:0]    status_o
);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PROG_CYCLES - 1);

  logic          busy_q, busy_n;
  logic          wel_q, wel_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] idx_q, idx_n;
  logic [7:0]    dat_q, dat_n;
  logic          prot, start, set_wel, done;

  always_comb begin
    prot    = int'(idx_i) >= PROT_START;
    start   = frame_end_i & prog_ok_i & wel_q & ~busy_q & ~prot;
    set_wel = frame_end_i & wren_ok_i & ~busy_q;
    done    = busy_q & (cnt_q == '0);
    busy_n = busy_q;
    wel_n  = wel_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    dat_n  = dat_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CNT_LOAD;
      idx_n  = idx_i;
      dat_n  = data_i;
    end else if (busy_q && !done) begin
      cnt_n = cnt_q - 1'b1;
    end
    if (done) begin
      busy_n = 1'b0;
      wel_n  = 1'b0;
    end
    if (set_wel) wel_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
    end else begin
      busy_q <= busy_n;
      wel_q  <= wel_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      dat_q  <= dat_n;
    end
  end

  assign tgt_idx_o = idx_q;
  assign wr_en_o   = done;
  assign wr_data_o = old_i & dat_q;
  assign busy_o    = busy_q;
  assign status_o  = {6'b0, wel_q, busy_q};

  a_r6_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q));
  a_r3_wel_not_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> !$past(busy_q));
  a_r8_wel_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q);
  a_r9_no_protected_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (int'(idx_q) < PROT_START));
endmodule

// File: rtl/spif_frame.sv
`timescale 1ns/1ps
module spif_frame
  import spif_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          hold_s,
  input  logic          busy_i,
  input  logic [7:0]    status_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_idx_o,
  output logic          frame_end_o,
  output logic          prog_ok_o,
  output logic          wren_ok_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  logic          sck_d, cs_d;
  logic [5:0]    cnt_q, cnt_n;
  logic          long_q, long_n;
  logic [7:0]    op_q, op_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [7:0]    data_q, data_n;
  logic [7:0]    sh_q, sh_n;
  logic          sdo_q, sdo_n;
  logic          act_q, act_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          blk_q, blk_n;
  logic          sel, hold_act, rise, fall, out_phase;
  logic [7:0]    load_byte;

  always_comb begin
    sel       = ~cs_s;
    hold_act  = sel & ~hold_s;
    rise      = sel & ~hold_act & sck_s & ~sck_d;
    fall      = sel & ~hold_act & ~sck_s & sck_d;
    out_phase = ((op_q == OP_RDSR) && (cnt_q >= B_CMD)) ||
                ((op_q == OP_READ) && (cnt_q >= B_ADDR) && !blk_q);
    rd_idx_o  = (cnt_q == B_ADDR) ? addr_q : ptr_q;
    load_byte = (op_q == OP_RDSR) ? status_i : rd_data_i;
  end

  always_comb begin
    cnt_n  = cnt_q;
    long_n = long_q;
    op_n   = op_q;
    addr_n = addr_q;
    data_n = data_q;
    sh_n   = sh_q;
    sdo_n  = sdo_q;
    act_n  = act_q;
    ptr_n  = ptr_q;
    blk_n  = blk_q;
    if (!sel) begin
      cnt_n  = '0;
      long_n = 1'b0;
      act_n  = 1'b0;
      blk_n  = 1'b0;
    end else begin
      if (rise) begin
        if (cnt_q < B_CMD)       op_n   = {op_q[6:0], sdi_s};
        else if (cnt_q < B_ADDR) addr_n = {addr_q[AW-2:0], sdi_s};
        else if (cnt_q < B_PROG) data_n = {data_q[6:0], sdi_s};
        if (cnt_q == B_CMD - 6'd1) blk_n = busy_i;
        if (cnt_q == B_WRAP) begin
          cnt_n  = B_PROG;
          long_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 6'd1;
        end
      end
      if (fall && out_phase) begin
        act_n = 1'b1;
        if (cnt_q[2:0] == 3'd0) begin
          sdo_n = load_byte[7];
          sh_n  = {load_byte[6:0], 1'b0};
          if (op_q == OP_READ) ptr_n = rd_idx_o + 1'b1;
        end else begin
          sdo_n = sh_q[7];
          sh_n  = {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      cnt_q  <= '0;
      long_q <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      sh_q   <= '0;
      sdo_q  <= 1'b0;
      act_q  <= 1'b0;
      ptr_q  <= '0;
      blk_q  <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      cs_d   <= cs_s;
      cnt_q  <= cnt_n;
      long_q <= long_n;
      op_q   <= op_n;
      addr_q <= addr_n;
      data_q <= data_n;
      sh_q   <= sh_n;
      sdo_q  <= sdo_n;
      act_q  <= act_n;
      ptr_q  <= ptr_n;
      blk_q  <= blk_n;
    end
  end

  assign frame_end_o = cs_s & ~cs_d;
  assign prog_ok_o   = (cnt_q == B_PROG) & ~long_q & (op_q == OP_PROG);
  assign wren_ok_o   = (cnt_q == B_CMD) & (op_q == OP_WREN);
  assign addr_o      = addr_q;
  assign data_o      = data_q;
  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = act_q & sel & ~hold_act;

  a_r10_hold_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |=> $stable(cnt_q));
  a_r2_sdo_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(fall));
  a_r5_blocked_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && op_q == OP_READ) |-> !sdo_oe_o);
  a_r11_no_output_in_header: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < B_CMD) |-> !sdo_oe_o);
endmodule

// File: rtl/spif_target.sv
`timescale 1ns/1ps
module spif_target #(
  parameter int MEM_BYTES   = 256,
  parameter int PROG_CYCLES = 64,
  parameter int PROT_START  = 192,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic hold_n,
  output logic sdo,
  output logic sdo_oe
);
  localparam int AW = $clog2(MEM_BYTES);

  logic [3:0]    pins_s;
  logic [AW-1:0] rd_idx, addr, tgt_idx, wr_idx;
  logic [7:0]    rd_data, old_data, data, wr_data, status;
  logic          frame_end, prog_ok, wren_ok, wr_en, busy;

  spif_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hold_n, cs_n, sck, sdi}), .q(pins_s)
  );

  spif_frame #(.AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]), .hold_s(pins_s[3]),
    .busy_i(busy), .status_i(status), .rd_data_i(rd_data), .rd_idx_o(rd_idx),
    .frame_end_o(frame_end), .prog_ok_o(prog_ok), .wren_ok_o(wren_ok),
    .addr_o(addr), .data_o(data), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  spif_prog #(.AW(AW), .PROG_CYCLES(PROG_CYCLES), .PROT_START(PROT_START)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .frame_end_i(frame_end), .prog_ok_i(prog_ok), .wren_ok_i(wren_ok),
    .idx_i(addr), .data_i(data), .old_i(old_data), .tgt_idx_o(tgt_idx),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .busy_o(busy), .status_o(status)
  );

  assign wr_idx = tgt_idx;

  spif_array #(.DEPTH(MEM_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_idx(rd_idx), .ra_data(rd_data),
    .rb_idx(tgt_idx), .rb_data(old_data)
  );
endmodule

// File: tb/spif_target_tb.sv
`timescale 1ns/1ps
module spif_target_tb;
  localparam int HALF = 40;
  localparam int PROG = 1000;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, sdi, hold_n;
  logic sdo, sdo_oe;
  int   tests = 0, fails = 0;
  bit   mode3 = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  spif_target #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .hold_n(hold_n), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      sdi = tx[i];
      #HALF;
      rx[i] = sdo_oe ? sdo : 1'b0;
      if (sdo_oe) oe_seen = 1'b1;
      sck = 1'b1;
      #HALF;
    end
  endtask

  task automatic fbegin();
    sck = mode3;
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic fend();
    if (!mode3) sck = 1'b0;
    #HALF;
    cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic raw(input logic [47:0] b, input int n);
    logic [7:0] r; bit o;
    fbegin();
    for (int k = 0; k < n; k++) xfer(b[47-8*k -: 8], r, o);
    fend();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r; bit o;
    fbegin();
    xfer(8'h05, r, o);
    xfer(8'h00, st, o);
    fend();
  endtask

  task automatic wren();
    raw({8'h06, 40'h0}, 1);
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] d);
    raw({8'h02, a, d, 8'h00}, 5);
  endtask

  task automatic read2(input logic [23:0] a, output logic [7:0] d0, output logic [7:0] d1,
                       output bit hdr_oe, output bit dat_oe);
    logic [7:0] r; bit o, o2;
    hdr_oe = 1'b0;
    fbegin();
    xfer(8'h03, r, o); hdr_oe |= o;
    for (int k = 2; k >= 0; k--) begin xfer(a[8*k +: 8], r, o); hdr_oe |= o; end
    xfer(8'h00, d0, o);
    xfer(8'h00, d1, o2);
    dat_oe = o & o2;
    fend();
  endtask

  task automatic wait_prog();
    repeat (PROG + 100) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] st, d0, d1; bit h, o;
    chk("R1 sdo_oe after reset", sdo_oe, 0);
    rdsr(st);
    chk("R1 R4 status after reset", st, 8'h00);
    read2(24'h000005, d0, d1, h, o);
    chk("R1 erased byte 5", d0, 8'hFF);
    chk("R1 erased byte 6", d1, 8'hFF);
    chk("R11 no output in header", h, 0);
    chk("R11 output during read data", o, 1);
  endtask

  task automatic t_no_wel();
    logic [7:0] st, d0, d1; bit h, o;
    prog(24'h000010, 8'h3C);
    rdsr(st);
    chk("R6 program without latch not busy", st, 8'h00);
    read2(24'h000010, d0, d1, h, o);
    chk("R6 program without latch ignored", d0, 8'hFF);
  endtask

  task automatic t_basic();
    logic [7:0] st, d0, d1; bit h, o;
    wren();
    rdsr(st);
    chk("R3 latch set", st, 8'h02);
    prog(24'h000010, 8'hA5);
    rdsr(st);
    chk("R8 busy during program", st, 8'h03);
    read2(24'h000010, d0, d1, h, o);
    chk("R5 read while busy drives nothing", {h, o}, 0);
    wait_prog();
    rdsr(st);
    chk("R8 busy and latch clear after program", st, 8'h00);
    read2(24'h000010, d0, d1, h, o);
    chk("R6 programmed byte", d0, 8'hA5);
    chk("R5 next byte untouched", d1, 8'hFF);
  endtask

  task automatic t_and();
    logic [7:0] d0, d1; bit h, o;
    wren(); prog(24'h000011, 8'hF0); wait_prog();
    wren(); prog(24'h000011, 8'h3C); wait_prog();
    read2(24'h000011, d0, d1, h, o);
    chk("R7 old AND new", d0, 8'h30);
  endtask

  task automatic t_wren_busy();
    logic [7:0] st;
    wren(); prog(24'h000012, 8'h77);
    wren();
    wait_prog();
    rdsr(st);
    chk("R3 latch request ignored while busy", st, 8'h00);
  endtask

  task automatic t_protect();
    logic [7:0] st, d0, d1; bit h, o;
    wren();
    prog(24'h0000C4, 8'h00);
    rdsr(st);
    chk("R9 protected program: latch kept, not busy", st, 8'h02);
    read2(24'h0000C4, d0, d1, h, o);
    chk("R9 protected byte unchanged", d0, 8'hFF);
  endtask

  task automatic t_frame_len();
    logic [7:0] st, d0, d1; bit h, o;
    raw({8'h02, 24'h000013, 16'h0}, 4);
    rdsr(st);
    chk("R6 32-bit program frame ignored", st, 8'h02);
    raw({8'h02, 24'h000013, 8'h00, 8'h00}, 6);
    rdsr(st);
    chk("R6 48-bit program frame ignored", st, 8'h02);
    read2(24'h000013, d0, d1, h, o);
    chk("R6 byte after bad frames", d0, 8'hFF);
  endtask

  task automatic t_mode3();
    logic [7:0] st, d0, d1; bit h, o;
    mode3 = 1'b1;
    sck = 1'b1;
    #(4*HALF);
    prog(24'h000020, 8'h12); wait_prog();
    wren(); prog(24'h000021, 8'h34); wait_prog();
    rdsr(st);
    chk("R2 R4 mode 3 status", st, 8'h00);
    read2(24'h000020, d0, d1, h, o);
    chk("R2 mode 3 first byte", d0, 8'h12);
    chk("R5 address increments", d1, 8'h34);
    mode3 = 1'b0;
    sck = 1'b0;
    #(4*HALF);
    read2(24'h010020, d0, d1, h, o);
    chk("R2 R5 mode 0, high address bits ignored", {d0, d1}, 16'h1234);
  endtask

  task automatic t_hold();
    logic [7:0] r, d0, d1; bit o;
    fbegin();
    xfer(8'h03, r, o);
    xfer(8'h00, r, o); xfer(8'h00, r, o); xfer(8'h20, r, o);
    xfer(8'h00, d0, o);
    hold_n = 1'b0;
    #HALF;
    chk("R10 sdo_oe low during hold", sdo_oe, 0);
    for (int k = 0; k < 4; k++) begin
      sck = 1'b0; sdi = 1'b1; #HALF;
      sck = 1'b1; #HALF;
    end
    chk("R10 sdo_oe still low during hold", sdo_oe, 0);
    hold_n = 1'b1;
    #HALF;
    xfer(8'h00, d1, o);
    fend();
    chk("R10 byte before hold", d0, 8'h12);
    chk("R10 byte resumes after hold", d1, 8'h34);
  endtask

  task automatic t_rdsr_repeat();
    logic [7:0] r, a, b; bit o;
    wren();
    fbegin();
    xfer(8'h05, r, o);
    xfer(8'h00, a, o);
    xfer(8'h00, b, o);
    fend();
    chk("R4 status repeats", {a, b}, 16'h0202);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; hold_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_no_wel();
    t_basic();
    t_and();
    t_wren_busy();
    t_protect();
    t_frame_len();
    t_mode3();
    t_hold();
    t_rdsr_repeat();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule